// File: doc/BRIEF.md
# Cross-Clock Mailbox Bypass Register

This block carries one word at a time from a sending port to a receiving port that runs on its own, unrelated clock, without using the FIFO storage. The sender stores the word with a mailbox-qualified write. From then on the word is held unchanged, and further mailbox writes are refused, until the receiver consumes it with a mailbox-qualified read.

Each side has an active-low mail flag. `wr_mail_n` is in the sender's clock domain. It drops on the edge that stores a word, and it stays low until the receiver's acknowledgement has crossed back, which also tells the sender when the mailbox can take the next word. `rd_mail_n` is in the receiver's clock domain and is low while unread mail is waiting. The set and clear events cross between the domains as toggles through multi-flop synchronizers, so a single word can never raise two notices or lose its notice.

The block also contains the receiver's output selector. It drives the mail word when the receiver's mailbox select is high and the FIFO output word when that select is low.

Top module: `mbx_bypass`

## Requirements
- R1: A sender-side edge with `w_cs_n`=0, `w_wr_rd`=1, `w_en`=1, `w_mb_sel`=1 and `wr_mail_n`=1 stores `w_data` in the mail register, and `wr_mail_n` is 0 after that edge.
- R2: While `wr_mail_n` is 0, mailbox writes are refused and the stored word does not change.
- R3: A sender-side edge with any write qualifier inactive (`w_cs_n`=1, `w_wr_rd`=0, `w_en`=0 or `w_mb_sel`=0) neither stores data nor changes `wr_mail_n`.
- R4: After an accepted write, `rd_mail_n` goes to 0 within SYNC_STAGES+1 receiver clock edges.
- R5: A receiver-side edge with `r_cs_n`=0, `r_wr_rd`=0, `r_en`=1, `r_mb_sel`=1 while `rd_mail_n` is 0 sets `rd_mail_n` to 1 on that edge. `wr_mail_n` then returns to 1 within SYNC_STAGES+1 sender clock edges.
- R6: While `rd_mail_n` is 0, a receiver-side edge without all four read qualifiers leaves `rd_mail_n` at 0.
- R7: `r_data` equals the mail register when `r_mb_sel`=1 and equals `r_fifo_q` when `r_mb_sel`=0.
- R8: While `rst_n` is 0, `wr_mail_n` and `rd_mail_n` are both 1.
- R9: One accepted write produces exactly one pending notice. After it is consumed, `rd_mail_n` stays at 1 until the next accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Sender-side clock |
| rclk | input | 1 | Receiver-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| w_cs_n | input | 1 | Sender chip select, active low |
| w_wr_rd | input | 1 | Sender direction, 1 = write |
| w_en | input | 1 | Sender transfer enable |
| w_mb_sel | input | 1 | Sender mailbox select |
| w_data | input | WIDTH | Word offered by the sender |
| wr_mail_n | output | 1 | Sender-domain flag, low while mail is unconsumed |
| r_cs_n | input | 1 | Receiver chip select, active low |
| r_wr_rd | input | 1 | Receiver direction, 0 = read |
| r_en | input | 1 | Receiver transfer enable |
| r_mb_sel | input | 1 | Receiver mailbox select, also steers `r_data` |
| r_fifo_q | input | WIDTH | FIFO output register word |
| r_data | output | WIDTH | Selected word for the receiver |
| rd_mail_n | output | 1 | Receiver-domain flag, low while unread mail waits |

## Verification
The bench builds the block with its default values: WIDTH of 36 and SYNC_STAGES of 2. The two clocks have unrelated periods, so toggles arrive at varying phases of the other clock. With two synchronizer stages the bounded flag latencies are short enough to test directly in each direction. The bench also exercises refused writes, partly qualified accesses, and complete write/consume round trips back to back. With 36 bits, data patterns that differ in the top and bottom bits show any truncation of the stored word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // true when a port access selects the mailbox in the given direction
    function automatic logic mail_access(input logic cs_n, input logic wr_rd,
                                         input logic en, input logic mb_sel,
                                         input logic want_write);
        return !cs_n && en && mb_sel && (wr_rd == want_write);
    endfunction

endpackage

// File: rtl/mbx_tog_sync.sv
module mbx_tog_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d;
        end else begin : g_many
            always_comb chain_d = {chain_q[LAST-1:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[LAST];
endmodule

// File: rtl/mbx_wr_side.sv
module mbx_wr_side
    import mbx_pkg::*;
#(
    parameter int WIDTH = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_rd,
    input  logic             en,
    input  logic             mb_sel,
    input  logic [WIDTH-1:0] data,
    input  logic             ack_tog_s,
    output logic             req_tog,
    output logic [WIDTH-1:0] mail,
    output logic             mail_n
);
    typedef struct packed {
        logic             tog;
        logic [WIDTH-1:0] word;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic      idle;

    always_comb begin
        idle = (st_q.tog == ack_tog_s);
        st_d = st_q;
        if (idle && mail_access(cs_n, wr_rd, en, mb_sel, 1'b1)) begin
            st_d.tog  = ~st_q.tog;
            st_d.word = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_tog = st_q.tog;
    assign mail    = st_q.word;
    assign mail_n  = (st_q.tog == ack_tog_s);
endmodule

// File: rtl/mbx_rd_side.sv
module mbx_rd_side
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_rd,
    input  logic en,
    input  logic mb_sel,
    input  logic req_tog_s,
    output logic ack_tog,
    output logic mail_n
);
    typedef struct packed {
        logic tog;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      pending;

    always_comb begin
        pending = (req_tog_s != st_q.tog);
        st_d    = st_q;
        if (pending && mail_access(cs_n, wr_rd, en, mb_sel, 1'b0))
            st_d.tog = req_tog_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_tog = st_q.tog;
    assign mail_n  = !pending;
endmodule

// File: rtl/mbx_bypass.sv
module mbx_bypass #(
    parameter int WIDTH       = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             w_cs_n,
    input  logic             w_wr_rd,
    input  logic             w_en,
    input  logic             w_mb_sel,
    input  logic [WIDTH-1:0] w_data,
    output logic             wr_mail_n,
    input  logic             r_cs_n,
    input  logic             r_wr_rd,
    input  logic             r_en,
    input  logic             r_mb_sel,
    input  logic [WIDTH-1:0] r_fifo_q,
    output logic [WIDTH-1:0] r_data,
    output logic             rd_mail_n
);
    logic             req_tog, req_tog_s;
    logic             ack_tog, ack_tog_s;
    logic [WIDTH-1:0] mail_q;

    mbx_wr_side #(.WIDTH(WIDTH)) u_wr (
        .clk(wclk), .rst_n(rst_n), .cs_n(w_cs_n), .wr_rd(w_wr_rd),
        .en(w_en), .mb_sel(w_mb_sel), .data(w_data), .ack_tog_s(ack_tog_s),
        .req_tog(req_tog), .mail(mail_q), .mail_n(wr_mail_n)
    );

    mbx_tog_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(rclk), .rst_n(rst_n), .d(req_tog), .q(req_tog_s)
    );

    mbx_rd_side u_rd (
        .clk(rclk), .rst_n(rst_n), .cs_n(r_cs_n), .wr_rd(r_wr_rd),
        .en(r_en), .mb_sel(r_mb_sel), .req_tog_s(req_tog_s),
        .ack_tog(ack_tog), .mail_n(rd_mail_n)
    );

    mbx_tog_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(wclk), .rst_n(rst_n), .d(ack_tog), .q(ack_tog_s)
    );

    assign r_data = r_mb_sel ? mail_q : r_fifo_q;
endmodule

// File: rtl/mbx_bypass_chk.sv
module mbx_bypass_chk #(
    parameter int WIDTH = 36
) (
    input logic             wclk,
    input logic             rclk,
    input logic             rst_n,
    input logic             w_cs_n,
    input logic             w_wr_rd,
    input logic             w_en,
    input logic             w_mb_sel,
    input logic             wr_mail_n,
    input logic             r_cs_n,
    input logic             r_wr_rd,
    input logic             r_en,
    input logic             r_mb_sel,
    input logic             rd_mail_n,
    input logic [WIDTH-1:0] mail_q
);
    logic w_req, r_req;
    assign w_req = !w_cs_n && w_wr_rd && w_en && w_mb_sel;
    assign r_req = !r_cs_n && !r_wr_rd && r_en && r_mb_sel;

    assert_write_sets_flag_R1: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_mail_n && w_req) |=> !wr_mail_n);

    assert_blocked_hold_R2: assert property (@(posedge wclk) disable iff (!rst_n)
        !wr_mail_n |=> $stable(mail_q));

    assert_idle_write_side_R3: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_mail_n && !w_req) |=> $stable(mail_q));

    assert_read_clears_R5: assert property (@(posedge rclk) disable iff (!rst_n)
        (!rd_mail_n && r_req) |=> rd_mail_n);

    assert_no_clear_without_read_R6: assert property (@(posedge rclk) disable iff (!rst_n)
        (!rd_mail_n && !r_req) |=> !rd_mail_n);

    assert_pending_implies_blocked_R2: assert property (@(posedge rclk) disable iff (!rst_n)
        !rd_mail_n |-> !wr_mail_n);

    assert_reset_flags_R8: assert property (@(posedge wclk)
        !rst_n |-> (wr_mail_n && rd_mail_n));
endmodule

bind mbx_bypass mbx_bypass_chk #(.WIDTH(WIDTH)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .w_cs_n(w_cs_n), .w_wr_rd(w_wr_rd), .w_en(w_en), .w_mb_sel(w_mb_sel),
    .wr_mail_n(wr_mail_n),
    .r_cs_n(r_cs_n), .r_wr_rd(r_wr_rd), .r_en(r_en), .r_mb_sel(r_mb_sel),
    .rd_mail_n(rd_mail_n), .mail_q(mail_q)
);

// File: tb/mbx_bypass_tb.sv
`timescale 1ns/1ps
module mbx_bypass_tb;
    localparam int W  = 36;
    localparam int SS = 2;

    logic wclk = 0, rclk = 0, rst_n = 0;
    logic w_cs_n = 1, w_wr_rd = 0, w_en = 0, w_mb_sel = 0;
    logic [W-1:0] w_data = '0;
    logic r_cs_n = 1, r_wr_rd = 1, r_en = 0, r_mb_sel = 0;
    logic [W-1:0] r_fifo_q = '0;
    logic wr_mail_n, rd_mail_n;
    logic [W-1:0] r_data;

    int n_run = 0, n_fail = 0;

    always #4   wclk = ~wclk;
    always #5.5 rclk = ~rclk;

    mbx_bypass #(.WIDTH(W), .SYNC_STAGES(SS)) u_dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .w_cs_n(w_cs_n), .w_wr_rd(w_wr_rd), .w_en(w_en), .w_mb_sel(w_mb_sel),
        .w_data(w_data), .wr_mail_n(wr_mail_n),
        .r_cs_n(r_cs_n), .r_wr_rd(r_wr_rd), .r_en(r_en), .r_mb_sel(r_mb_sel),
        .r_fifo_q(r_fifo_q), .r_data(r_data), .rd_mail_n(rd_mail_n)
    );

    task automatic check(input logic ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic cs_n, input logic wr_rd, input logic en,
                            input logic mb, input logic [W-1:0] d);
        @(negedge wclk);
        w_cs_n = cs_n; w_wr_rd = wr_rd; w_en = en; w_mb_sel = mb; w_data = d;
        @(negedge wclk);
        w_cs_n = 1; w_wr_rd = 0; w_en = 0; w_mb_sel = 0;
    endtask

    task automatic do_read(input logic cs_n, input logic wr_rd, input logic en,
                           input logic mb);
        @(negedge rclk);
        r_cs_n = cs_n; r_wr_rd = wr_rd; r_en = en; r_mb_sel = mb;
        @(negedge rclk);
        r_cs_n = 1; r_wr_rd = 1; r_en = 0; r_mb_sel = 0;
    endtask

    // wait for rd_mail_n low, bounded in receiver edges; returns edges used
    task automatic wait_rd_low(output int n);
        n = 0;
        while (rd_mail_n && n < SS + 3) begin @(negedge rclk); n++; end
    endtask

    task automatic wait_wr_high(output int n);
        n = 0;
        while (!wr_mail_n && n < SS + 3) begin @(negedge wclk); n++; end
    endtask

    task automatic peek_mail(output logic [W-1:0] v);
        @(negedge rclk);
        r_mb_sel = 1;
        #1 v = r_data;
        r_mb_sel = 0;
    endtask

    task automatic t_reset;
        #1;
        check(wr_mail_n === 1'b1, "R8 wr_mail_n in reset", W'(wr_mail_n), W'(1));
        check(rd_mail_n === 1'b1, "R8 rd_mail_n in reset", W'(rd_mail_n), W'(1));
    endtask

    task automatic t_round_trip(input logic [W-1:0] d);
        int n;
        logic [W-1:0] v;
        do_write(0, 1, 1, 1, d);
        check(wr_mail_n === 1'b0, "R1 flag low after write", W'(wr_mail_n), W'(0));
        wait_rd_low(n);
        check(rd_mail_n === 1'b0 && n <= SS + 1, "R4 notice latency",
              W'(n), W'(SS + 1));
        peek_mail(v);
        check(v === d, "R1 stored word", v, d);
        do_read(0, 0, 1, 1);
        check(rd_mail_n === 1'b1, "R5 read clears rd flag", W'(rd_mail_n), W'(1));
        wait_wr_high(n);
        check(wr_mail_n === 1'b1 && n <= SS + 1, "R5 ack latency", W'(n), W'(SS + 1));
    endtask

    task automatic t_blocked;
        int n;
        logic [W-1:0] v;
        do_write(0, 1, 1, 1, 36'h0_1234_5678);
        do_write(0, 1, 1, 1, 36'hF_EDCB_A987);
        check(wr_mail_n === 1'b0, "R2 flag still low", W'(wr_mail_n), W'(0));
        wait_rd_low(n);
        repeat (3) @(negedge rclk);
        peek_mail(v);
        check(v === 36'h0_1234_5678, "R2 refused write kept word", v, 36'h0_1234_5678);
        do_read(0, 0, 1, 1);
        wait_wr_high(n);
    endtask

    task automatic t_partial_write;
        logic [W-1:0] v;
        do_write(1, 1, 1, 1, 36'hA_AAAA_AAAA);
        do_write(0, 0, 1, 1, 36'hA_AAAA_AAAA);
        do_write(0, 1, 0, 1, 36'hA_AAAA_AAAA);
        do_write(0, 1, 1, 0, 36'hA_AAAA_AAAA);
        check(wr_mail_n === 1'b1, "R3 flag unchanged", W'(wr_mail_n), W'(1));
        repeat (4) @(negedge rclk);
        check(rd_mail_n === 1'b1, "R3 no notice", W'(rd_mail_n), W'(1));
        peek_mail(v);
        check(v === 36'h0_1234_5678, "R3 word unchanged", v, 36'h0_1234_5678);
    endtask

    task automatic t_partial_read;
        int n;
        do_write(0, 1, 1, 1, 36'h5_5555_5555);
        wait_rd_low(n);
        do_read(1, 0, 1, 1);
        do_read(0, 1, 1, 1);
        do_read(0, 0, 0, 1);
        do_read(0, 0, 1, 0);
        check(rd_mail_n === 1'b0, "R6 flag survives partial reads", W'(rd_mail_n), W'(0));
        check(wr_mail_n === 1'b0, "R6 sender still blocked", W'(wr_mail_n), W'(0));
        do_read(0, 0, 1, 1);
        wait_wr_high(n);
        repeat (10) @(negedge rclk);
        check(rd_mail_n === 1'b1, "R9 single notice per write", W'(rd_mail_n), W'(1));
    endtask

    task automatic t_mux;
        @(negedge rclk);
        r_fifo_q = 36'h9_0F0F_0F0F;
        r_mb_sel = 0;
        #1 check(r_data === 36'h9_0F0F_0F0F, "R7 fifo path", r_data, 36'h9_0F0F_0F0F);
        r_mb_sel = 1;
        #1 check(r_data === 36'h5_5555_5555, "R7 mail path", r_data, 36'h5_5555_5555);
        r_mb_sel = 0;
    endtask

    initial begin : watchdog
        #1_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge rclk);
        t_reset();
        rst_n = 1;
        repeat (3) @(negedge wclk);
        t_round_trip(36'h8_0000_0001);
        t_round_trip(36'h7_FFFF_FFFE);
        t_blocked();
        t_partial_write();
        t_partial_read();
        t_mux();
        t_round_trip(36'hC_3C3C_3C3C);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule